// File: doc/BRIEF.md
# Serially Configured NAND Logic Cell

This block is a small logic cell whose function is chosen at run time by a 5-bit configuration word. Two operand selectors each pick one of four neighbour signals (east, west, south, north) and feed a two-input NAND gate. A final stage either passes the NAND result or inverts it. The same hardware can therefore act as NAND or AND of any two neighbours. It acts as OR when neighbouring cells supply the operands already inverted.

The configuration word enters one bit per clock through a serial input while the shift enable is high. The shifting does not touch the active function. A one-cycle apply strobe copies the shifted word into a shadow register, and the shadow register drives the selectors. The cell output therefore stays steady while a new word is being loaded. The last bit of the shift register appears on a serial chain output. Cells can then be daisy-chained and loaded from one bit stream, with the word for the farthest cell sent first.

Top module: `rcell_core`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, the shift register and the shadow register both hold all zeros. Then `cfg_sout` is 0 and `cell_y` equals NOT `nb_east`, because both selectors pick east and the output stage passes the NAND result.
- R2: While `cfg_shift_en` is low, the shift register holds its contents and `cfg_sout` does not change.
- R3: Each clock with `cfg_shift_en` high moves the register one place toward the MSB and loads `cfg_sin` at the LSB. The first bit of a 5-bit burst ends in bit 4. `cfg_sout` always shows bit 4, so that a second cell fed from it receives the bits that were shifted earlier.
- R4: Shifting without an apply strobe leaves the active configuration, and hence `cell_y`, unchanged.
- R5: Word bits [3:2] select operand A: 00 = east, 01 = west, 10 = south, 11 = north.
- R6: Word bits [1:0] select operand B, with the same codes as R5.
- R7: With word bit 4 = 0, `cell_y` = NOT(A AND B). With word bit 4 = 1, `cell_y` = A AND B.
- R8: An apply strobe copies the shift register value from before that clock's shift, even when `cfg_shift_en` is high in the same cycle.
- R9: `cell_y` follows the neighbour inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_shift_en | input | 1 | Shift the configuration register this cycle |
| cfg_apply | input | 1 | Copy the shift register into the active shadow register |
| cfg_sout | output | 1 | Serial chain output (shift register MSB) |
| nb_east | input | 1 | East neighbour signal (select code 00) |
| nb_west | input | 1 | West neighbour signal (select code 01) |
| nb_south | input | 1 | South neighbour signal (select code 10) |
| nb_north | input | 1 | North neighbour signal (select code 11) |
| cell_y | output | 1 | Cell output |

## Verification
The clocked properties check on every cycle that the shift register holds when the enable is low and advances into the chain output when it is high. They also check that the shadow register changes only on an apply strobe, and that it then takes the value from before the shift. A further property checks that the inverting output stage produces the AND of the two selected operands. Only the bench scenarios can show the other behaviours. These are the exact mapping of select codes to neighbours across all words and input patterns, the reset value seen at the ports, the MSB-first ordering through a two-cell daisy chain, and an output that tracks the inputs with no clock in between.

// File: rtl/rcell_pkg.sv
package rcell_pkg;
  localparam int unsigned NBR_CNT = 4;
  localparam int unsigned SEL_W   = $clog2(NBR_CNT);
  localparam int unsigned CFG_W   = 1 + 2 * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    NBR_EAST  = 2'd0,
    NBR_WEST  = 2'd1,
    NBR_SOUTH = 2'd2,
    NBR_NORTH = 2'd3
  } nbr_sel_e;

  typedef struct packed {
    logic             invert_out;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
  } cell_cfg_t;
endpackage

// File: rtl/rcell_rst_sync.sv
module rcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rcell_cfg_chain.sv
module rcell_cfg_chain #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sin,
  input  logic         shift_en,
  input  logic         apply,
  output logic         sout,
  output logic [W-1:0] active
);
  logic [W-1:0] shift_q, shift_d;
  logic [W-1:0] shadow_q, shadow_d;

  always_comb begin
    shift_d = shift_q;
    if (shift_en) begin
      shift_d = {shift_q[W-2:0], sin};
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    if (apply) begin
      shadow_d = shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      shadow_q <= '0;
    end else begin
      shift_q  <= shift_d;
      shadow_q <= shadow_d;
    end
  end

  assign sout   = shift_q[W-1];
  assign active = shadow_q;

  // R2: register holds with the enable low
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shift_q));

  // R3: the bit below the MSB moves out onto the chain output
  a_r3_shift_to_sout: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sout == $past(shift_q[W-2]));

  // R4: active word unchanged without the strobe
  a_r4_shadow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(shadow_q));

  // R8: strobe captures the pre-shift contents
  a_r8_apply_captures: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> shadow_q == $past(shift_q));
endmodule

// File: rtl/rcell_sel_mux.sv
module rcell_sel_mux #(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic          dout
);
  always_comb begin
    dout = din[sel];
  end
endmodule

// File: rtl/rcell_out_stage.sv
module rcell_out_stage (
  input  logic op_a,
  input  logic op_b,
  input  logic invert,
  output logic y
);
  logic nand_v;

  always_comb begin
    nand_v = ~(op_a & op_b);
    y      = invert ? ~nand_v : nand_v;
  end
endmodule

// File: rtl/rcell_core.sv
module rcell_core
  import rcell_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic cfg_sin,
  input  logic cfg_shift_en,
  input  logic cfg_apply,
  output logic cfg_sout,
  input  logic nb_east,
  input  logic nb_west,
  input  logic nb_south,
  input  logic nb_north,
  output logic cell_y
);
  logic             rst_n;
  logic [CFG_W-1:0] active_word;
  cell_cfg_t        cfg;
  logic [NBR_CNT-1:0] nbr_vec;
  logic [1:0]       operand;
  logic [SEL_W-1:0] op_sel [2];

  rcell_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  rcell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .sin      (cfg_sin),
    .shift_en (cfg_shift_en),
    .apply    (cfg_apply),
    .sout     (cfg_sout),
    .active   (active_word)
  );

  always_comb begin
    cfg       = cell_cfg_t'(active_word);
    op_sel[0] = cfg.sel_a;
    op_sel[1] = cfg.sel_b;
    nbr_vec[NBR_EAST]  = nb_east;
    nbr_vec[NBR_WEST]  = nb_west;
    nbr_vec[NBR_SOUTH] = nb_south;
    nbr_vec[NBR_NORTH] = nb_north;
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_operand
    rcell_sel_mux #(.N(NBR_CNT), .SW(SEL_W)) u_mux (
      .din  (nbr_vec),
      .sel  (op_sel[gi]),
      .dout (operand[gi])
    );
  end

  rcell_out_stage u_out (
    .op_a   (operand[0]),
    .op_b   (operand[1]),
    .invert (cfg.invert_out),
    .y      (cell_y)
  );

  // R7: inverting stage yields the AND of the chosen operands
  a_r7_and_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.invert_out |-> cell_y == (operand[0] & operand[1]));
endmodule

// File: tb/tb_rcell_core.sv
`timescale 1ns/1ps
module tb_rcell_core;
  localparam real TCK = 8.0;

  logic clk = 1'b0;
  logic arst_n, sin, shift_en, apply;
  logic e, w, s, n;
  logic sout, y, sout2, y2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCK/2) clk = ~clk;

  rcell_core dut (
    .clk(clk), .arst_n(arst_n), .cfg_sin(sin), .cfg_shift_en(shift_en),
    .cfg_apply(apply), .cfg_sout(sout), .nb_east(e), .nb_west(w),
    .nb_south(s), .nb_north(n), .cell_y(y)
  );

  rcell_core dut_nxt (
    .clk(clk), .arst_n(arst_n), .cfg_sin(sout), .cfg_shift_en(shift_en),
    .cfg_apply(apply), .cfg_sout(sout2), .nb_east(e), .nb_west(w),
    .nb_south(s), .nb_north(n), .cell_y(y2)
  );

  // {word[4:0], n, s, w, e, expected}
  localparam logic [9:0] VEC [16] = '{
    {5'b00000, 4'b0001, 1'b0}, {5'b00000, 4'b0000, 1'b1},
    {5'b00101, 4'b0010, 1'b0}, {5'b00110, 4'b0110, 1'b0},
    {5'b00110, 4'b0010, 1'b1}, {5'b10110, 4'b0110, 1'b1},
    {5'b10110, 4'b0100, 1'b0}, {5'b01100, 4'b1001, 1'b0},
    {5'b11100, 4'b1001, 1'b1}, {5'b11100, 4'b1000, 1'b0},
    {5'b01011, 4'b0100, 1'b1}, {5'b11011, 4'b1100, 1'b1},
    {5'b00111, 4'b0000, 1'b1}, {5'b00111, 4'b1010, 1'b0},
    {5'b10001, 4'b0011, 1'b1}, {5'b10001, 4'b0001, 1'b0}
  };

  function automatic logic model(input logic [4:0] c, input logic [3:0] d);
    logic a, b, nd;
    a  = d[c[3:2]];
    b  = d[c[1:0]];
    nd = ~(a & b);
    return c[4] ? ~nd : nd;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_in(input logic [3:0] d);
    {n, s, w, e} = d;
  endtask

  task automatic shift_word(input logic [4:0] wd);
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk);
      sin = wd[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_apply();
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
  endtask

  initial begin
    #(TCK * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] wa, wb;
    arst_n = 1'b0; sin = 1'b0; shift_en = 1'b0; apply = 1'b0;
    set_in(4'b0000);
    repeat (3) @(negedge clk);
    // R1: values during reset
    #1 check("R1", sout, 1'b0);
    check("R1", y, 1'b1);
    set_in(4'b0001);
    #1 check("R1", y, 1'b0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sout, 1'b0);
    check("R1", y, 1'b0);

    // R5 R6 R7: vector table
    foreach (VEC[i]) begin
      shift_word(VEC[i][9:5]);
      pulse_apply();
      set_in(VEC[i][4:1]);
      #1 check("R7 table", y, VEC[i][0]);
    end

    // R5 R6 R7: full sweep of words and inputs against the model
    for (int c = 0; c < 32; c++) begin
      shift_word(5'(c));
      pulse_apply();
      for (int d = 0; d < 16; d++) begin
        set_in(4'(d));
        #1 check("R5/R6 sweep", y, model(5'(c), 4'(d)));
      end
    end

    // R3: MSB first, chain output shows bit 4
    wa = 5'b10110;
    shift_word(wa);
    check("R3", sout, wa[4]);
    sin = 1'b0; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    check("R3", sout, wa[3]);

    // R2: idle cycles hold the register
    repeat (4) @(negedge clk);
    check("R2", sout, wa[3]);
    pulse_apply();
    // register now {wa[3:0],0} = 01100
    for (int d = 0; d < 16; d++) begin
      set_in(4'(d));
      #1 check("R2", y, model(5'b01100, 4'(d)));
    end

    // R4: shifting without apply leaves function unchanged
    wa = 5'b10001;
    shift_word(wa);
    pulse_apply();
    shift_word(5'b01110);
    for (int d = 0; d < 16; d++) begin
      set_in(4'(d));
      #1 check("R4", y, model(wa, 4'(d)));
    end

    // R8: apply while shifting captures the old contents
    wa = 5'b00110;
    shift_word(wa);
    sin = 1'b1; shift_en = 1'b1; apply = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; apply = 1'b0;
    set_in(4'b0110);
    #1 check("R8", y, model(wa, 4'b0110));
    pulse_apply();
    #1 check("R8", y, model({wa[3:0], 1'b1}, 4'b0110));

    // R9: output follows inputs with no clock edge
    shift_word(5'b10110);
    pulse_apply();
    set_in(4'b0110);
    #1 check("R9", y, 1'b1);
    #1 set_in(4'b0100);
    #1 check("R9", y, 1'b0);
    #1 set_in(4'b0110);
    #1 check("R9", y, 1'b1);

    // R3: daisy chain, far cell's word sent first
    wa = 5'b11100;
    wb = 5'b00101;
    shift_word(wa);
    shift_word(wb);
    pulse_apply();
    for (int d = 0; d < 16; d++) begin
      set_in(4'(d));
      #1 check("R3 chain near", y, model(wb, 4'(d)));
      check("R3 chain far", y2, model(wa, 4'(d)));
    end

    // R1: reset mid-operation clears both registers
    @(negedge clk);
    arst_n = 1'b0;
    set_in(4'b0000);
    #1 check("R1", y, 1'b1);
    check("R1", sout, 1'b0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    set_in(4'b0001);
    #1 check("R1", y, 1'b0);
    check("R1", y2, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule